// File: doc/BRIEF.md
# Host Channel Access Port

This block sits between a 32-bit host register port and the two per-channel memories of a time-division switch. One host word covers four consecutive channels, so a single access touches a group of four entries. The host address carries a window select bit and a word index k. Word k covers channels 4k to 4k+3. Channel 4k+j always maps to byte lane j, bits 8j+7 to 8j.

The connection window reaches the low message byte, bits 7:0, of connection memory entries. A write updates only the byte lanes whose enable bit is set. The block performs each lane as a read followed by a write of the same entry, so bits 31:8 of the entry come back unchanged. A read of this window returns the four low bytes. The data window returns the captured input bytes of four channels. This window is read-only: a write to it is answered with a bus error and causes no memory access. Captured data may trail the line by up to three frames. That lag belongs to the capture memory and is not added here.

The memories are single-ported with one cycle of read latency. The block works through the four lanes one after another, issuing at most one memory strobe per cycle. The host holds `req_valid_i` and the request fields until it sees `req_ready_o`.

Top module: `host_chan_port`

## Requirements
- R1: A write to the connection window (address bit WORD_W = 0) at word k with `req_be_i[j]`=1 sets bits 7:0 of connection entry 4k+j to `req_wdata_i[8j+7:8j]`.
- R2: Bits 31:8 of every entry written in R1 keep their prior value. Each write strobe follows a read strobe to the same entry in the previous cycle.
- R3: For a connection window write, a lane with `req_be_i[j]`=0 leaves entry 4k+j unchanged and gets no write strobe. With all enables clear, no write strobe is issued.
- R4: A read of the data window (address bit WORD_W = 1) at word k returns the captured byte of input channel 4k+j in `resp_rdata_o[8j+7:8j]`. Byte enables are ignored.
- R5: A read of the connection window at word k returns bits 7:0 of entries 4k..4k+3, packed as in R4.
- R6: A write to the data window drives `resp_err_o` high in the same cycle as `req_ready_o`, one cycle after the request is taken. No memory strobe is issued and no memory entry changes.
- R7: `req_ready_o` is high for exactly one cycle per request. `resp_err_o` is high only together with `req_ready_o`, and stays low for every valid access.
- R8: At most one of `cm_re_o`, `cm_we_o`, `dm_re_o` is high in any cycle. Every request is answered within 9 cycles of being taken.
- R9: During and right after reset, `req_ready_o`, `resp_err_o` and all memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present, held until ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | WORD_W+1 | Bit WORD_W = window select, low bits = word index k |
| req_wdata_i | input | 32 | Four message bytes, lane j = channel 4k+j |
| req_be_i | input | 4 | Byte lane write enables |
| req_ready_o | output | 1 | One-cycle response strobe |
| resp_err_o | output | 1 | Bus error, valid with ready |
| resp_rdata_o | output | 32 | Read data, valid with ready |
| cm_re_o | output | 1 | Connection memory read strobe |
| cm_we_o | output | 1 | Connection memory write strobe |
| cm_addr_o | output | CH_W | Connection memory entry index |
| cm_wdata_o | output | 32 | Connection memory write data |
| cm_rdata_i | input | 32 | Connection memory read data, one cycle after read strobe |
| dm_re_o | output | 1 | Data memory read strobe |
| dm_addr_o | output | CH_W | Data memory channel index |
| dm_rdata_i | input | 8 | Captured channel byte, one cycle after read strobe |

## Verification
A wrong lane counter or word register shows up at the end of the transaction that uses it. Bytes land in the wrong entry or lane, and a full comparison of the connection memory picks that up before the next request. A broken read-modify-write path corrupts bits 31:8 of an entry in the same way. A stuck state or a missed error decode shows at the ports right away. Ready arrives late, more than once, or without the error flag, and memory strobes appear where none are allowed.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    OP_CM_WR = 2'd0,
    OP_CM_RD = 2'd1,
    OP_DM_RD = 2'd2,
    OP_BAD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_USE   = 2'd2,
    ST_RESP  = 2'd3
  } st_e;
endpackage

// File: rtl/hcp_decode.sv
module hcp_decode
  import hcp_pkg::*;
(
  input  logic write_i,
  input  logic dwin_i,
  output op_e  op_o
);
  always_comb begin
    unique case ({dwin_i, write_i})
      2'b00:   op_o = OP_CM_RD;
      2'b01:   op_o = OP_CM_WR;
      2'b10:   op_o = OP_DM_RD;
      default: op_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/hcp_seq.sv
module hcp_seq
  import hcp_pkg::*;
#(
  parameter int unsigned WORD_W = 4,
  localparam int unsigned CH_W  = WORD_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANES-1:0]  be_i,
  output logic              acc_o,
  output logic [1:0]        lane_o,
  output logic [CH_W-1:0]   ch_o,
  output op_e               op_o,
  output logic              cm_re_o,
  output logic              cm_we_o,
  output logic              dm_re_o,
  output logic              cap_o,
  output logic              ready_o,
  output logic              err_o
);
  st_e               st_q;
  op_e               op_q;
  logic [WORD_W-1:0] word_q;
  logic [LANES-1:0]  be_q;
  logic [1:0]        lane_q;
  logic              err_q;
  logic              lane_act;

  assign lane_act = (op_q != OP_CM_WR) || be_q[lane_q];
  assign acc_o    = (st_q == ST_IDLE) && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_CM_RD;
      word_q <= '0;
      be_q   <= '0;
      lane_q <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (valid_i) begin
          op_q   <= op_i;
          word_q <= word_i;
          be_q   <= be_i;
          lane_q <= '0;
          err_q  <= (op_i == OP_BAD);
          st_q   <= (op_i == OP_BAD) ? ST_RESP : ST_ISSUE;
        end
        ST_ISSUE: begin
          if (lane_act)            st_q   <= ST_USE;
          else if (lane_q == 2'd3) st_q   <= ST_RESP;
          else                     lane_q <= lane_q + 2'd1;
        end
        ST_USE: begin
          if (lane_q == 2'd3) st_q <= ST_RESP;
          else begin
            lane_q <= lane_q + 2'd1;
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign lane_o  = lane_q;
  assign ch_o    = {word_q, lane_q};
  assign op_o    = op_q;
  assign cm_re_o = (st_q == ST_ISSUE) && lane_act && (op_q != OP_DM_RD);
  assign dm_re_o = (st_q == ST_ISSUE) && lane_act && (op_q == OP_DM_RD);
  assign cm_we_o = (st_q == ST_USE) && (op_q == OP_CM_WR);
  assign cap_o   = (st_q == ST_USE) && (op_q != OP_CM_WR);
  assign ready_o = (st_q == ST_RESP);
  assign err_o   = (st_q == ST_RESP) && err_q;

  // R6
  bad_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && op_i == OP_BAD) |=> (ready_o && err_o));
  // R7
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R7
  err_with_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o);
  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cm_re_o, cm_we_o, dm_re_o}));
  // R2
  rmw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_we_o |-> ($past(cm_re_o) && $stable(ch_o)));
  // R6
  no_strobe_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !(cm_re_o || cm_we_o || dm_re_o));
endmodule

// File: rtl/hcp_pack.sv
module hcp_pack
  import hcp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acc_i,
  input  logic        write_i,
  input  logic [31:0] wdata_i,
  input  logic        cap_i,
  input  logic [1:0]  lane_i,
  input  op_e         op_i,
  input  logic [7:0]  cm_byte_i,
  input  logic [7:0]  dm_byte_i,
  output logic [7:0]  wbyte_o,
  output logic [31:0] rdata_o
);
  logic [7:0] byte_q [LANES];
  logic [7:0] cap_byte;

  assign cap_byte = (op_i == OP_DM_RD) ? dm_byte_i : cm_byte_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           byte_q[g] <= '0;
      else if (acc_i)                        byte_q[g] <= write_i ? wdata_i[8*g +: 8] : 8'h00;
      else if (cap_i && lane_i == 2'(g))     byte_q[g] <= cap_byte;
    end
    assign rdata_o[8*g +: 8] = byte_q[g];
  end

  assign wbyte_o = byte_q[lane_i];
endmodule

// File: rtl/host_chan_port.sv
module host_chan_port
  import hcp_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned WORD_W = CH_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [WORD_W:0]   req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [3:0]        req_be_i,
  output logic              req_ready_o,
  output logic              resp_err_o,
  output logic [31:0]       resp_rdata_o,
  output logic              cm_re_o,
  output logic              cm_we_o,
  output logic [CH_W-1:0]   cm_addr_o,
  output logic [31:0]       cm_wdata_o,
  input  logic [31:0]       cm_rdata_i,
  output logic              dm_re_o,
  output logic [CH_W-1:0]   dm_addr_o,
  input  logic [7:0]        dm_rdata_i
);
  op_e             dec_op, cur_op;
  logic            acc, cap;
  logic [1:0]      lane;
  logic [CH_W-1:0] ch;
  logic [7:0]      wbyte;

  hcp_decode u_dec (
    .write_i (req_write_i),
    .dwin_i  (req_addr_i[WORD_W]),
    .op_o    (dec_op)
  );

  hcp_seq #(.WORD_W(WORD_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .op_i    (dec_op),
    .word_i  (req_addr_i[WORD_W-1:0]),
    .be_i    (req_be_i),
    .acc_o   (acc),
    .lane_o  (lane),
    .ch_o    (ch),
    .op_o    (cur_op),
    .cm_re_o (cm_re_o),
    .cm_we_o (cm_we_o),
    .dm_re_o (dm_re_o),
    .cap_o   (cap),
    .ready_o (req_ready_o),
    .err_o   (resp_err_o)
  );

  hcp_pack u_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .write_i   (req_write_i),
    .wdata_i   (req_wdata_i),
    .cap_i     (cap),
    .lane_i    (lane),
    .op_i      (cur_op),
    .cm_byte_i (cm_rdata_i[7:0]),
    .dm_byte_i (dm_rdata_i),
    .wbyte_o   (wbyte),
    .rdata_o   (resp_rdata_o)
  );

  assign cm_addr_o  = ch;
  assign dm_addr_o  = ch;
  // message byte replaces only the low byte of the entry just read
  assign cm_wdata_o = {cm_rdata_i[31:8], wbyte};

  // R9
  reset_quiet_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !(req_ready_o || resp_err_o || cm_re_o || cm_we_o || dm_re_o));
endmodule

// File: tb/host_chan_port_tb.sv
module host_chan_port_tb;
  localparam int NUM_CH = 64;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int WORD_W = CH_W - 2;
  localparam int NWORD  = NUM_CH / 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [WORD_W:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_be = '0;
  logic req_ready, resp_err;
  logic [31:0] resp_rdata;
  logic cm_re, cm_we, dm_re;
  logic [CH_W-1:0] cm_addr, dm_addr;
  logic [31:0] cm_wdata, cm_rdata;
  logic [7:0] dm_rdata;

  logic [31:0] cm_mem [NUM_CH];
  logic [31:0] exp_cm [NUM_CH];
  logic [7:0]  dm_mem [NUM_CH];
  int n_tests = 0, n_fail = 0;
  int we_cnt = 0, any_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_chan_port #(.NUM_CH(NUM_CH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be),
    .req_ready_o(req_ready), .resp_err_o(resp_err), .resp_rdata_o(resp_rdata),
    .cm_re_o(cm_re), .cm_we_o(cm_we), .cm_addr_o(cm_addr), .cm_wdata_o(cm_wdata),
    .cm_rdata_i(cm_rdata), .dm_re_o(dm_re), .dm_addr_o(dm_addr), .dm_rdata_i(dm_rdata)
  );

  always @(posedge clk) begin
    if (cm_re) cm_rdata <= cm_mem[cm_addr];
    if (cm_we) cm_mem[cm_addr] <= cm_wdata;
    if (dm_re) dm_rdata <= dm_mem[dm_addr];
    if (cm_we) we_cnt++;
    if (cm_re || cm_we || dm_re) any_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cm_read(input int k);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[8*j +: 8] = exp_cm[4*k+j][7:0];
    return r;
  endfunction

  function automatic logic [31:0] exp_dm_read(input int k);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[8*j +: 8] = dm_mem[4*k+j];
    return r;
  endfunction

  task automatic xact(input bit wr, input bit dwin, input int k, input logic [31:0] wd,
                      input logic [3:0] be, output logic [31:0] rd, output bit err,
                      output int cyc, output int wes, output int anys);
    int we0, any0;
    @(negedge clk);
    we0 = we_cnt; any0 = any_cnt;
    req_valid = 1; req_write = wr; req_addr = {dwin, WORD_W'(k)}; req_wdata = wd; req_be = be;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!req_ready && cyc < 40);
    rd = resp_rdata; err = resp_err;
    req_valid = 0;
    @(negedge clk);
    check(!req_ready, "R7 ready one cycle", {31'b0, req_ready}, 32'h0);
    wes = we_cnt - we0; anys = any_cnt - any0;
  endtask

  task automatic cm_compare(input string req);
    int bad = -1;
    for (int i = 0; i < NUM_CH; i++) if (cm_mem[i] !== exp_cm[i] && bad < 0) bad = i;
    if (bad < 0) check(1, req, 0, 0);
    else check(0, req, cm_mem[bad], exp_cm[bad]);
  endtask

  task automatic do_cm_write(input int k, input logic [31:0] wd, input logic [3:0] be);
    logic [31:0] rd; bit err; int cyc, wes, anys;
    xact(1, 0, k, wd, be, rd, err, cyc, wes, anys);
    for (int j = 0; j < 4; j++) if (be[j]) exp_cm[4*k+j][7:0] = wd[8*j +: 8];
    cm_compare("R1/R2 connection entries after write");
    check(wes == $countones(be), "R3 write strobe count", wes, $countones(be));
    check(!err, "R7 no error on valid write", {31'b0, err}, 0);
    check(cyc <= 9, "R8 response latency", cyc, 9);
  endtask

  task automatic do_read(input bit dwin, input int k);
    logic [31:0] rd, ex; bit err; int cyc, wes, anys;
    xact(0, dwin, k, $urandom, 4'($urandom), rd, err, cyc, wes, anys);
    ex = dwin ? exp_dm_read(k) : exp_cm_read(k);
    check(rd === ex, dwin ? "R4 data window read" : "R5 connection window read", rd, ex);
    check(!err && wes == 0, "R7 read no error/no write", {30'b0, err, wes != 0}, 0);
    check(cyc <= 9, "R8 response latency", cyc, 9);
  endtask

  task automatic do_bad_write(input int k);
    logic [31:0] rd; bit err; int cyc, wes, anys;
    xact(1, 1, k, $urandom, 4'hf, rd, err, cyc, wes, anys);
    check(err, "R6 error on data window write", {31'b0, err}, 1);
    check(cyc == 1, "R6 error response cycle", cyc, 1);
    check(anys == 0, "R6 no memory strobes", anys, 0);
    cm_compare("R6 memory unchanged");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < NUM_CH; i++) begin
      cm_mem[i] = $urandom; exp_cm[i] = cm_mem[i]; dm_mem[i] = 8'($urandom);
    end
    repeat (3) @(negedge clk);
    // R9
    check(!req_ready && !resp_err && !cm_re && !cm_we && !dm_re, "R9 reset quiet",
          {27'b0, req_ready, resp_err, cm_re, cm_we, dm_re}, 0);
    rst_ni = 1;
    @(negedge clk);
    check(!req_ready && !cm_re && !cm_we && !dm_re, "R9 quiet after reset",
          {28'b0, req_ready, cm_re, cm_we, dm_re}, 0);

    // directed corners
    do_cm_write(0, 32'h44332211, 4'hf);              // R1 R2 all lanes
    do_read(0, 0);                                    // R5
    do_cm_write(NWORD-1, 32'hAABBCCDD, 4'b1010);      // R3 partial lanes, last word
    do_cm_write(3, 32'hFFFFFFFF, 4'h0);               // R3 no lanes
    do_read(1, NWORD-1);                              // R4 last word
    do_bad_write(2);                                  // R6
    do_read(1, 0);

    for (int t = 0; t < 200; t++) begin
      int sel = $urandom_range(0, 3);
      int k   = $urandom_range(0, NWORD-1);
      case (sel)
        0: do_cm_write(k, $urandom, 4'($urandom));
        1: do_read(0, k);
        2: do_read(1, k);
        default: do_bad_write(k);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule